// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block watches one active-low external interrupt pin and holds the result in a sticky interrupt flag. A mask bit decides whether the flag becomes an interrupt request. A mode bit chooses between two detection rules. In the first, only a falling edge sets the flag. In the second, a falling edge or a held low level sets it. Software sees the flag through a four-bit register. It clears the flag in two steps: first it reads the register while the flag is set, and then it writes the acknowledge bit.

The block also drives a wakeup output. While the clock runs, as in the wait state, the wakeup follows the unmasked flag. In the stop state the clock is gated, so a separate capture element, clocked by the pin itself, raises the wakeup on the falling edge. When the clock resumes, that captured event is folded into the flag.

A debug-break input and a break-clear-enable control decide whether software may clear the flag while the system is halted. When clearing is frozen, hardware can still set the flag. A read made before the break keeps its first-step effect, so an acknowledge written after the break completes the clear.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, the register reads 4'b0010: mode 0 (edge), mask 1 (masked), acknowledge 0, flag 0. irq_req and wake are both 0.
- R2: In edge mode (bit 0 = 0), a falling edge on pin_n sets the flag, which reads back on bit 3. If the pin stays low after the flag is cleared, the flag does not set again.
- R3: irq_req is high exactly when the flag is set and the mask (bit 1) is 0. With the mask at 1, the flag still latches, but irq_req stays low.
- R4: In level mode (bit 0 = 1), the flag stays set while the synchronized pin is low, even across an acknowledge. Once the pin is high, an acknowledge clears the flag.
- R5: An acknowledge is a write with bit 2 = 1. It clears the flag only if a read saw the flag set after the flag last became armable. An acknowledge with no prior read leaves the flag set. Bit 2 always reads 0.
- R6: If a new detection arrives in the same cycle as an acknowledge, the flag stays set.
- R7: When the clock is running, wake is high whenever the flag is set and the mask is 0.
- R8: With stop_mode = 1 and the mask at 0, a falling edge on pin_n drives wake high with no clock edge. After the clock resumes and stop_mode falls, the flag is set.
- R9: When brk_active = 1 and brk_clr_en = 0, reads and acknowledges do not change the flag or its read-armed state. A read made before the break, followed by an acknowledge after the break, clears the flag.
- R10: When brk_active = 1 and brk_clr_en = 1, a read followed by an acknowledge clears the flag, and the flag stays clear after the break ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; may be gated in stop |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| rd_en | input | 1 | Register read strobe (first clear step) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data: bit0 mode, bit1 mask, bit2 acknowledge |
| rd_data | output | 4 | Read data: bit0 mode, bit1 mask, bit2 reads 0, bit3 flag |
| brk_active | input | 1 | System halted for debug |
| brk_clr_en | input | 1 | Allow status clearing during a debug break |
| stop_mode | input | 1 | Stop state active; clock may be stopped |
| irq_req | output | 1 | Interrupt request to the processor |
| wake | output | 1 | Wakeup request to leave wait or stop |

## Verification
The bench builds the block with the default two-stage synchronizer. With that setting, a pin change reaches the flag on the third clock edge, and this fixed latency lets the bench place an acknowledge exactly on the cycle in which a detection lands. It also stops the bench clock completely during stop, so the wakeup must appear in an interval with no edges at all. Random pulse patterns under random masks run alongside directed break-freeze sequences for both values of the clear-enable control.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W    = 4;
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_LEVEL = 1'b1
  } det_mode_e;

  typedef struct packed {
    logic flag;
    logic ack;
    logic mask;
    logic mode;
  } ctrl_reg_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  det_mode_e mode,
  output logic      hit
);
  logic prev_q;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign fall = prev_q & ~pin_s;

  always_comb begin
    unique case (mode)
      DET_LEVEL: hit = fall | ~pin_s;
      default:   hit = fall;
    endcase
  end
endmodule

// File: rtl/extirq_stop_wake.sv
module extirq_stop_wake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic stop_mode,
  input  logic mask,
  output logic evt,
  output logic evt_set
);
  logic evt_s;
  logic clr_q;
  logic evt_clr;

  assign evt_clr = clr_q | ~rst_n;

  always_ff @(negedge pin_n or posedge evt_clr) begin
    if (evt_clr)                evt <= 1'b0;
    else if (stop_mode && !mask) evt <= 1'b1;
  end

  extirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_evt_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (evt),
    .q     (evt_s)
  );

  assign evt_set = evt_s & ~stop_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= evt_set;
  end
endmodule

// File: rtl/extirq_flag.sv
module extirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic rd_en,
  input  logic ack_wr,
  input  logic frozen,
  output logic flag,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_in)                            flag <= 1'b1;
      else if (ack_wr && armed && !frozen)   flag <= 1'b0;

      if (!flag)                  armed <= 1'b0;
      else if (ack_wr && !frozen) armed <= 1'b0;
      else if (rd_en && !frozen)  armed <= 1'b1;
    end
  end

  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && flag) |=> flag);

  assert_frozen_noarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !armed) |=> !armed);

  assert_race_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && ack_wr) |=> flag);

  assert_ack_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !armed && flag) |=> flag);
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             brk_active,
  input  logic             brk_clr_en,
  input  logic             stop_mode,
  output logic             irq_req,
  output logic             wake
);
  det_mode_e mode_q;
  logic      mask_q;
  logic      pin_s;
  logic      det_hit;
  logic      evt;
  logic      evt_set;
  logic      flag;
  logic      armed;
  logic      frozen;
  logic      ack_wr;
  ctrl_reg_t view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DET_EDGE;
      mask_q <= 1'b1;
    end else if (wr_en) begin
      mode_q <= det_mode_e'(wr_data[BIT_MODE]);
      mask_q <= wr_data[BIT_MASK];
    end
  end

  assign ack_wr = wr_en & wr_data[BIT_ACK];
  assign frozen = brk_active & ~brk_clr_en;

  extirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_n),
    .q     (pin_s)
  );

  extirq_detect u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_s (pin_s),
    .mode  (mode_q),
    .hit   (det_hit)
  );

  extirq_stop_wake #(.SYNC_STAGES(SYNC_STAGES)) u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (pin_n),
    .stop_mode (stop_mode),
    .mask      (mask_q),
    .evt       (evt),
    .evt_set   (evt_set)
  );

  extirq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_in (det_hit | evt_set),
    .rd_en  (rd_en),
    .ack_wr (ack_wr),
    .frozen (frozen),
    .flag   (flag),
    .armed  (armed)
  );

  always_comb begin
    view.flag = flag;
    view.ack  = 1'b0;
    view.mask = mask_q;
    view.mode = mode_q;
  end

  assign rd_data = view;
  assign irq_req = flag & ~mask_q;
  assign wake    = ~mask_q & (flag | evt);

  assert_wake_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !mask_q) |-> wake);

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DET_LEVEL && !pin_s) |=> flag);
endmodule

// File: tb/sim_extirq_ctrl.sv
`timescale 1ns/1ps
module sim_extirq_ctrl;
  logic       clk = 1'b0;
  logic       clk_en = 1'b1;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'b0;
  logic [3:0] rd_data;
  logic       brk_active = 1'b0;
  logic       brk_clr_en = 1'b0;
  logic       stop_mode = 1'b0;
  logic       irq_req;
  logic       wake;
  int         checks = 0;
  int         errors = 0;

  always begin
    #5;
    if (clk_en) clk = ~clk;
  end

  extirq_ctrl #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .brk_active(brk_active),
    .brk_clr_en(brk_clr_en), .stop_mode(stop_mode), .irq_req(irq_req), .wake(wake)
  );

  function automatic logic exp_irq(logic f, logic m);
    return f & ~m;
  endfunction

  function automatic logic [3:0] exp_reg(logic f, logic m, logic md);
    return {f, 1'b0, m, md};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [3:0] v);
    rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int low_cycles);
    pin_n = 1'b0;
    tick(low_cycles);
    pin_n = 1'b1;
    tick(4);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] v;
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(v);
    check("R1 reg", v, 4'b0010);
    check("R1 irq", {3'b0, irq_req}, 4'b0);
    check("R1 wake", {3'b0, wake}, 4'b0);

    // R2 edge set, held low no retrigger
    wr(4'b0000);
    pin_n = 1'b0;
    tick(4);
    rd(v);
    check("R2 flag set", v, exp_reg(1'b1, 1'b0, 1'b0));
    check("R3 irq unmasked", {3'b0, irq_req}, {3'b0, exp_irq(1'b1, 1'b0)});
    check("R7 wake", {3'b0, wake}, 4'b0001);
    wr(4'b0100);
    tick(3);
    rd(v);
    check("R2 no retrigger while low", v, 4'b0000);
    check("R5 ack bit reads 0", {3'b0, v[2]}, 4'b0);
    pin_n = 1'b1;
    tick(3);

    // R5 unarmed ack leaves flag
    pulse(2);
    wr(4'b0100);
    tick(1);
    check("R5 unarmed ack", {3'b0, irq_req}, 4'b0001);
    rd(v);
    wr(4'b0100);
    tick(1);
    check("R5 armed ack clears", {3'b0, irq_req}, 4'b0000);

    // R3 masked
    wr(4'b0010);
    pulse(2);
    check("R3 masked irq", {3'b0, irq_req}, 4'b0);
    check("R7 masked wake", {3'b0, wake}, 4'b0);
    rd(v);
    check("R3 flag latches masked", v, exp_reg(1'b1, 1'b1, 1'b0));
    wr(4'b0110);
    wr(4'b0000);

    // R4 level mode
    wr(4'b0001);
    pin_n = 1'b0;
    tick(4);
    rd(v);
    wr(4'b0101);
    tick(1);
    check("R4 level holds through ack", {3'b0, irq_req}, 4'b0001);
    pin_n = 1'b1;
    tick(3);
    rd(v);
    wr(4'b0101);
    tick(1);
    check("R4 clears after pin high", {3'b0, irq_req}, 4'b0000);
    wr(4'b0000);

    // R6 race: detection lands on the ack cycle
    pulse(2);
    rd(v);
    pin_n = 1'b0;
    tick(2);
    wr(4'b0100);
    check("R6 race keeps flag", {3'b0, irq_req}, 4'b0001);
    pin_n = 1'b1;
    tick(3);
    rd(v);
    wr(4'b0100);
    tick(1);
    check("R6 later clear", {3'b0, irq_req}, 4'b0000);

    // R9 frozen break
    pulse(2);
    brk_active = 1'b1;
    brk_clr_en = 1'b0;
    rd(v);
    wr(4'b0100);
    tick(1);
    check("R9 frozen ack", {3'b0, irq_req}, 4'b0001);
    brk_active = 1'b0;
    wr(4'b0100);
    tick(1);
    check("R9 break read did not arm", {3'b0, irq_req}, 4'b0001);
    rd(v);
    brk_active = 1'b1;
    wr(4'b0100);
    tick(1);
    check("R9 armed but frozen", {3'b0, irq_req}, 4'b0001);
    brk_active = 1'b0;
    wr(4'b0100);
    tick(1);
    check("R9 second step after break", {3'b0, irq_req}, 4'b0000);

    // R10 clear allowed in break
    pulse(2);
    brk_active = 1'b1;
    brk_clr_en = 1'b1;
    rd(v);
    wr(4'b0100);
    tick(1);
    check("R10 clear in break", {3'b0, irq_req}, 4'b0000);
    brk_active = 1'b0;
    brk_clr_en = 1'b0;
    tick(2);
    check("R10 stays clear", {3'b0, irq_req}, 4'b0000);

    // R8 stop with clock gated
    stop_mode = 1'b1;
    tick(1);
    clk_en = 1'b0;
    #20;
    pin_n = 1'b0;
    #1;
    check("R8 async wake", {3'b0, wake}, 4'b0001);
    check("R8 flag not yet set", {3'b0, irq_req}, 4'b0000);
    #10;
    pin_n = 1'b1;
    #2;
    check("R8 wake held", {3'b0, wake}, 4'b0001);
    clk_en = 1'b1;
    @(negedge clk);
    stop_mode = 1'b0;
    tick(8);
    check("R8 flag after resume", {3'b0, irq_req}, 4'b0001);
    rd(v);
    wr(4'b0100);
    tick(2);
    check("R8 wake released", {3'b0, wake}, 4'b0000);

    // random pulses, random mask (R2, R3, R7)
    for (int i = 0; i < 40; i++) begin
      logic m;
      logic p;
      m = 1'($urandom % 2);
      p = 1'($urandom % 2);
      wr({2'b00, m, 1'b0});
      if (p) pulse(1 + int'($urandom % 4));
      else tick(4);
      check("R3 random irq", {3'b0, irq_req}, {3'b0, exp_irq(p, m)});
      check("R7 random wake", {3'b0, wake}, {3'b0, exp_irq(p, m)});
      rd(v);
      check("R2 random flag", v, exp_reg(p, m, 1'b0));
      wr({2'b01, m, 1'b0});
      tick(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule